// File: doc/BRIEF.md
# Received Word Holding Latch with Label Gate

This block sits behind a serial bit decoder that reassembles 32-bit avionics data words. When the decoder signals that a word is complete, the block can compare two label bits of that word against a pair of programmed bits and drop words that do not match. It replaces the final bit with a parity verdict and stores the word. It then drives an active-low "word waiting" flag toward a host.

The host sees a 16-bit bus. It fetches the stored word as two halves, using an active-low read strobe together with a half-select line. The flag returns to its idle (high) level only once both halves have been fetched. If a newer accepted word arrives before then, the newer word replaces the stored one and the fetch starts over.

Top module: `arinc_word_latch`

## Requirements
- R1: With the filter enabled (`filt_en`=1), a completed word is stored only when its bit index 8 (word bit 9) equals `lbl_ref[0]` and its bit index 9 (word bit 10) equals `lbl_ref[1]`. A rejected word leaves the stored word and the flag unchanged.
- R2: With the filter disabled (`filt_en`=0), every completed word is stored, whatever its label bits.
- R3: When a completed word is stored at a clock edge, `word_rdy_n` is low from that edge on.
- R4: `word_rdy_n` stays low until both the low half and the high half have been read. It goes high at the edge that samples the second of the two distinct reads.
- R5: A newer accepted word replaces the stored word even if the older word was not yet fully read. Reads then return the newer word.
- R6: Bits 0..30 (word bits 1..31) are stored unchanged. Bit 31 (word bit 32) is stored as 0 when the count of ones over all 32 incoming bits is odd, and as 1 when that count is even.
- R7: A read with `half_sel`=0 returns bits 15:0 (word bits 1..16). A read with `half_sel`=1 returns bits 31:16 (word bits 17..32).
- R8: Reading the same half more than once does not count as reading both halves. Storing a new word forgets any halves already read.
- R9: When a read and an accepted word fall on the same edge, the new word is stored, `word_rdy_n` stays low and read tracking restarts. The read returns the previously stored word.
- R10: `rd_n` is active low and sampled on the rising clock edge. `rd_data` is registered: it changes only at an edge that samples `rd_n` low, and it holds otherwise.
- R11: After synchronous reset, `word_rdy_n` is high, `rd_data` is 0 and the stored word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eos | input | 1 | One-cycle pulse: a complete word is on `rx_word` |
| rx_word | input | 32 | Decoded word, bit 0 = first received bit |
| filt_en | input | 1 | Enables the two-bit label gate |
| lbl_ref | input | 2 | Programmed label bits, [0] vs word bit index 8, [1] vs index 9 |
| rd_n | input | 1 | Read strobe, active low |
| half_sel | input | 1 | 0 = low half, 1 = high half |
| rd_data | output | 16 | Registered read data |
| word_rdy_n | output | 1 | Word waiting, active low |

## Verification
The bench sweeps all combinations of filter enable, programmed bits and incoming label bits. A gate with a swapped or inverted comparison would store the wrong words, or keep the flag high after a good word. A parity sweep across words of every ones count from 0 to 32 catches an inverted or off-by-one parity mark. Reading one half twice catches tracking that counts any two reads as "both". A new word that lands between the two halves catches tracking that is not reset. A read on the same edge as a new word catches a design that lets the read clear the flag, or that returns the new word too early.

// File: rtl/arinc_latch_pkg.sv
package arinc_latch_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int LBL_POS = 8;

  typedef struct packed {
    logic lo;
    logic hi;
  } half_track_t;

  // Parity mark: 0 when the ones count is odd, 1 when it is even.
  function automatic logic parity_mark(input logic [WORD_W-1:0] w);
    return ~(^w);
  endfunction
endpackage

// File: rtl/alw_qualify.sv
module alw_qualify
  import arinc_latch_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int POS = LBL_POS
) (
  input  logic         eos,
  input  logic [W-1:0] word_in,
  input  logic         filt_en,
  input  logic [1:0]   lbl_ref,
  output logic         accept,
  output logic [W-1:0] word_fix
);
  logic lbl_hit;

  always_comb begin
    lbl_hit  = (word_in[POS+1:POS] == lbl_ref);
    accept   = eos && (!filt_en || lbl_hit);
    word_fix = {parity_mark(word_in), word_in[W-2:0]};
  end
endmodule

// File: rtl/alw_store.sv
module alw_store #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic [W-1:0] word_fix,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else if (accept)
      word_q <= word_fix;
  end

  assert_store_holds_R1: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(word_q));
endmodule

// File: rtl/alw_track.sv
module alw_track
  import arinc_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic rd_stb,
  input  logic half_sel,
  output logic ready
);
  half_track_t seen, seen_nx;

  always_comb begin
    seen_nx.lo = seen.lo | (ready & rd_stb & ~half_sel);
    seen_nx.hi = seen.hi | (ready & rd_stb &  half_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      seen  <= '0;
    end else if (accept) begin
      ready <= 1'b1;
      seen  <= '0;
    end else if (seen_nx.lo && seen_nx.hi) begin
      ready <= 1'b0;
      seen  <= '0;
    end else begin
      seen  <= seen_nx;
    end
  end

  assert_ready_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> ready);
  assert_ready_needs_read_R4: assert property (@(posedge clk) disable iff (rst)
    (ready && !rd_stb) |=> ready);
  assert_clear_needs_both_R8: assert property (@(posedge clk) disable iff (rst)
    (ready && !ready_next_guard()) |=> ready);

  function automatic logic ready_next_guard();
    return (seen.lo || seen.hi) && rd_stb;
  endfunction
endmodule

// File: rtl/alw_readport.sv
module alw_readport #(
  parameter int W = 32,
  parameter int H = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_stb,
  input  logic         half_sel,
  input  logic [W-1:0] word_q,
  output logic [H-1:0] rd_data
);
  localparam int NHALF = W / H;
  logic [H-1:0] halves [NHALF];

  for (genvar g = 0; g < NHALF; g++) begin : g_split
    assign halves[g] = word_q[g*H +: H];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_stb)
      rd_data <= halves[half_sel];
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
  assert_rd_low_half_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !half_sel) |=> rd_data == $past(word_q[H-1:0]));
endmodule

// File: rtl/arinc_word_latch.sv
module arinc_word_latch
  import arinc_latch_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int H   = HALF_W,
  parameter int POS = LBL_POS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         eos,
  input  logic [W-1:0] rx_word,
  input  logic         filt_en,
  input  logic [1:0]   lbl_ref,
  input  logic         rd_n,
  input  logic         half_sel,
  output logic [H-1:0] rd_data,
  output logic         word_rdy_n
);
  logic         accept;
  logic [W-1:0] word_fix;
  logic [W-1:0] word_q;
  logic         ready;
  logic         rd_stb;

  assign rd_stb     = ~rd_n;
  assign word_rdy_n = ~ready;

  alw_qualify #(.W(W), .POS(POS)) u_qual (
    .eos(eos), .word_in(rx_word), .filt_en(filt_en), .lbl_ref(lbl_ref),
    .accept(accept), .word_fix(word_fix)
  );

  alw_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .accept(accept), .word_fix(word_fix), .word_q(word_q)
  );

  alw_track u_track (
    .clk(clk), .rst(rst), .accept(accept), .rd_stb(rd_stb),
    .half_sel(half_sel), .ready(ready)
  );

  alw_readport #(.W(W), .H(H)) u_rd (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .half_sel(half_sel),
    .word_q(word_q), .rd_data(rd_data)
  );

  assert_nofilter_stores_R2: assert property (@(posedge clk) disable iff (rst)
    (eos && !filt_en) |=> !word_rdy_n);
  assert_reject_keeps_flag_R1: assert property (@(posedge clk) disable iff (rst)
    (eos && filt_en && rx_word[POS+1:POS] != lbl_ref && word_rdy_n && rd_n) |=> word_rdy_n);
  assert_parity_mark_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> word_q[W-1] == ~(^$past(rx_word)));
  assert_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> word_q[W-2:0] == $past(rx_word[W-2:0]));
  assert_same_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && !rd_n) |=> (!word_rdy_n && rd_data == $past(half_sel ? word_q[W-1:H] : word_q[H-1:0])));
  initial assert_reset_const_R11: assert (H * 2 == W);
endmodule

// File: tb/arinc_word_latch_test.sv
module arinc_word_latch_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        eos = 0;
  logic [31:0] rx_word = '0;
  logic        filt_en = 0;
  logic [1:0]  lbl_ref = '0;
  logic        rd_n = 1;
  logic        half_sel = 0;
  logic [15:0] rd_data;
  logic        word_rdy_n;

  int checks = 0;
  int errors = 0;
  logic done = 0;

  always #5 clk = ~clk;

  arinc_word_latch uut (
    .clk(clk), .rst(rst), .eos(eos), .rx_word(rx_word), .filt_en(filt_en),
    .lbl_ref(lbl_ref), .rd_n(rd_n), .half_sel(half_sel),
    .rd_data(rd_data), .word_rdy_n(word_rdy_n)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fixw(input logic [31:0] w);
    return {~(^w), w[30:0]};
  endfunction

  task automatic send(input logic [31:0] w);
    @(negedge clk); eos = 1; rx_word = w;
    @(negedge clk); eos = 0;
  endtask

  task automatic rd(input logic s, output logic [15:0] d);
    @(negedge clk); rd_n = 0; half_sel = s;
    @(negedge clk); rd_n = 1; d = rd_data;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] stored, w, seed, a, b;
    logic [15:0] d;
    logic acc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(word_rdy_n == 1, "R11 flag", {31'b0, word_rdy_n}, 1);
    check(rd_data == 0, "R11 data", {16'b0, rd_data}, 0);
    rd(0, d); check(d == 0, "R11 stored low", {16'b0, d}, 0);
    rd(1, d); check(d == 0, "R11 stored high", {16'b0, d}, 0);
    check(word_rdy_n == 1, "R11 reads idle", {31'b0, word_rdy_n}, 1);
    stored = '0;
    seed = 32'h1234_5678;

    // R1/R2 sweep
    for (int en = 0; en < 2; en++)
      for (int c = 0; c < 4; c++)
        for (int l = 0; l < 4; l++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          w = seed; w[9:8] = l[1:0];
          filt_en = en[0]; lbl_ref = c[1:0];
          acc = (en == 0) || (l == c);
          send(w);
          if (acc) begin
            stored = fixw(w);
            check(word_rdy_n == 0, en ? "R1 accept flag" : "R2 flag", {31'b0, word_rdy_n}, 0);
            rd(0, d); check(d == stored[15:0], "R7 low half", {16'b0, d}, {16'b0, stored[15:0]});
            check(word_rdy_n == 0, "R4 one half", {31'b0, word_rdy_n}, 0);
            rd(1, d); check(d == stored[31:16], "R7 high half", {16'b0, d}, {16'b0, stored[31:16]});
            check(word_rdy_n == 1, "R4 both halves", {31'b0, word_rdy_n}, 1);
          end else begin
            check(word_rdy_n == 1, "R1 reject flag", {31'b0, word_rdy_n}, 1);
            rd(0, d); check(d == stored[15:0], "R1 reject keeps word", {16'b0, d}, {16'b0, stored[15:0]});
          end
        end

    // R6 parity sweep over ones counts 0..32
    filt_en = 0;
    for (int k = 0; k <= 32; k++) begin
      w = (k == 32) ? 32'hFFFF_FFFF : ((32'd1 << k) - 1);
      w = {w[18:0], w[31:19]};
      send(w);
      rd(0, d); check(d == w[15:0], "R6 low bits kept", {16'b0, d}, {16'b0, w[15:0]});
      rd(1, d);
      check(d[15] == ((k % 2) == 0), "R6 parity mark", {31'b0, d[15]}, {31'b0, ((k % 2) == 0)});
      check(d[14:0] == w[30:16], "R6 high bits kept", {17'b0, d[14:0]}, {17'b0, w[30:16]});
    end

    // R8 same half twice
    a = 32'hA5A5_0F0F; send(a);
    rd(0, d); rd(0, d);
    check(word_rdy_n == 0, "R8 same half twice", {31'b0, word_rdy_n}, 0);
    rd(1, d); check(word_rdy_n == 1, "R8 then other half", {31'b0, word_rdy_n}, 1);

    // R5/R8 overwrite mid-read
    a = 32'h1111_2222; b = 32'h3C3C_4D4D;
    send(a); rd(0, d);
    send(b);
    rd(1, d); check(d == fixw(b)[31:16], "R5 new word read", {16'b0, d}, {16'b0, fixw(b)[31:16]});
    check(word_rdy_n == 0, "R8 tracking reset", {31'b0, word_rdy_n}, 0);
    rd(0, d); check(d == b[15:0], "R5 new low half", {16'b0, d}, {16'b0, b[15:0]});
    check(word_rdy_n == 1, "R4 after overwrite", {31'b0, word_rdy_n}, 1);

    // R9 read and word on the same edge
    a = 32'h0BAD_F00D; b = 32'h7777_8888;
    send(a); rd(0, d);
    @(negedge clk); eos = 1; rx_word = b; rd_n = 0; half_sel = 1;
    @(negedge clk); eos = 0; rd_n = 1;
    check(word_rdy_n == 0, "R9 flag stays", {31'b0, word_rdy_n}, 0);
    check(rd_data == fixw(a)[31:16], "R9 returns old", {16'b0, rd_data}, {16'b0, fixw(a)[31:16]});
    rd(1, d); check(d == fixw(b)[31:16], "R9 new word", {16'b0, d}, {16'b0, fixw(b)[31:16]});
    check(word_rdy_n == 0, "R9 tracking restarted", {31'b0, word_rdy_n}, 0);
    rd(0, d); check(word_rdy_n == 1, "R9 cleared", {31'b0, word_rdy_n}, 1);

    // R10 data holds without strobe
    repeat (3) @(negedge clk);
    check(rd_data == b[15:0], "R10 hold", {16'b0, rd_data}, {16'b0, b[15:0]});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule